// File: doc/BRIEF.md
# Coarse-Grain Context Switch Controller

This block manages four resident hardware register contexts in a coarse-grain multithreaded core. One context at a time owns the pipeline and is named by the context pointer. A thread keeps the pipeline until it hits a long-latency event, either a remote memory miss or a synchronization fault. At that point the controller drains the pipeline for a fixed number of flush cycles and saves the PC and next-PC of the faulting instruction, so that the instruction runs again when the thread resumes. It then hands the pipeline to another resident thread that is ready to run.

Contexts 0 to 2 hold user threads. The highest context (3) is kept for trap and message handlers, and it is entered directly whenever a trap or message event arrives. User contexts are chosen round-robin. If no user context is ready, control falls back to the handler context. Software runs the ready and suspended queues with load, unload, suspend and wake commands, and it can read the state of every context at all times. When a switch completes, the controller gives the fetch stage the restart PC and next-PC of the new context for one cycle.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset, `ctx_ptr` is 3 and `flush` is 0. The handler context is ACTIVE and every user context is UNLOADED. `restart_valid` is 0.
- R2: Each context state is a 2-bit code in `ctx_state[2*i+1:2*i]`: 0 UNLOADED, 1 LOADED, 2 ACTIVE, 3 SUSPENDED. `cmd_op` has four codes. 0 (load) moves UNLOADED to LOADED and stores `cmd_pc`/`cmd_npc` as the context's restart point. 1 (unload) moves LOADED or SUSPENDED to UNLOADED. 2 (suspend) moves LOADED to SUSPENDED. 3 (wake) moves SUSPENDED to LOADED. A command is ignored in any of these cases: its start state does not match, it targets context 3 or the ACTIVE context, it arrives while `flush` is 1, or it arrives in the cycle a switch is accepted.
- R3: A `miss_evt` in a user context marks that context SUSPENDED and saves `evt_pc`/`evt_npc` for it. The new context is the first LOADED user context found from (last user context run + 1) modulo 3, going upward. If there is none, the new context is context 3. After reset the last user context counts as 2.
- R4: `flush` rises in the cycle after an accepted event and stays at 1 for exactly FLUSH_CYCLES (4) cycles. While it is 1, no context is ACTIVE and `ctx_ptr` keeps its old value. `ctx_ptr` changes only in the cycle `flush` falls.
- R5: In the first cycle after `flush` falls, `restart_valid` is 1 for exactly one cycle, and `restart_pc`/`restart_npc` give the saved restart point of the new context. For context 3 the restart point is always TRAP_PC/TRAP_NPC.
- R6: Whenever `flush` is 0, exactly one context is ACTIVE, and it is the one named by `ctx_ptr`.
- R7: A `trap_evt` in a user context switches to context 3. The interrupted context becomes LOADED and its `evt_pc`/`evt_npc` are saved. If `miss_evt` arrives in the same cycle, `trap_evt` wins.
- R8: A `trap_ret` in context 3 marks context 3 LOADED and switches round-robin, as in R3, to a LOADED user context. If no user context is LOADED, the return is ignored. `miss_evt` in context 3 and `trap_ret` in a user context are ignored.
- R9: `miss_evt`, `trap_evt` and `trap_ret` have no effect while `flush` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_evt | input | 1 | Remote miss or synchronization fault in the active context |
| trap_evt | input | 1 | Trap or message arrival |
| trap_ret | input | 1 | Handler finished, return to a user thread |
| evt_pc | input | PC_W (32) | PC of the faulting or interrupted instruction |
| evt_npc | input | PC_W (32) | Next-PC of the faulting or interrupted instruction |
| cmd_valid | input | 1 | Software queue command strobe |
| cmd_op | input | 2 | Command code (R2) |
| cmd_ctx | input | CTX_W (2) | Context addressed by the command |
| cmd_pc | input | PC_W (32) | Restart PC stored by a load command |
| cmd_npc | input | PC_W (32) | Restart next-PC stored by a load command |
| flush | output | 1 | Pipeline drain in progress |
| ctx_ptr | output | CTX_W (2) | Active context pointer |
| restart_valid | output | 1 | One-cycle strobe after a switch |
| restart_pc | output | PC_W (32) | Restart PC of the context named by ctx_ptr |
| restart_npc | output | PC_W (32) | Restart next-PC of the context named by ctx_ptr |
| ctx_state | output | 2*NUM_CTX (8) | Packed per-context state codes |

## Verification
The bench targets several corner cases, each tied to a specific failure. A return from the handler when no user thread is loaded must be ignored; a design that got this wrong would flush and then re-enter the handler context or select an unloaded context. A miss when only the faulting thread was runnable must fall back to context 3; a faulty design would resume the suspended thread. A trap and a miss in the same cycle must leave the interrupted thread LOADED, not SUSPENDED. Events and commands during a flush, or in the cycle a switch is accepted, must be dropped. A design that let them through would change the target or the context states partway through a switch, and the bench would see the wrong pointer, state codes or restart PC once the flush ends.

// File: rtl/cxs_pkg.sv
package cxs_pkg;

  typedef enum logic [1:0] {
    CX_UNLOADED  = 2'd0,
    CX_LOADED    = 2'd1,
    CX_ACTIVE    = 2'd2,
    CX_SUSPENDED = 2'd3
  } cx_state_e;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_UNLOAD  = 2'd1,
    OP_SUSPEND = 2'd2,
    OP_WAKE    = 2'd3
  } cx_op_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_MISS   = 2'd1,
    EV_TRAP   = 2'd2,
    EV_RETURN = 2'd3
  } cx_event_e;

  // State reached by a software command; an illegal start state leaves it unchanged.
  function automatic cx_state_e cmd_next_state(input cx_state_e cur, input cx_op_e op);
    cx_state_e nxt;
    nxt = cur;
    case (op)
      OP_LOAD:    if (cur == CX_UNLOADED) nxt = CX_LOADED;
      OP_UNLOAD:  if (cur == CX_LOADED || cur == CX_SUSPENDED) nxt = CX_UNLOADED;
      OP_SUSPEND: if (cur == CX_LOADED) nxt = CX_SUSPENDED;
      OP_WAKE:    if (cur == CX_SUSPENDED) nxt = CX_LOADED;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

  // State left behind by the context that gives up the pipeline.
  function automatic cx_state_e leave_state(input cx_event_e ev);
    return (ev == EV_MISS) ? CX_SUSPENDED : CX_LOADED;
  endfunction

endpackage

// File: rtl/cxs_sequencer.sv
module cxs_sequencer
  import cxs_pkg::*;
#(
  parameter int NUM_CTX      = 4,
  parameter int FLUSH_CYCLES = 4,
  localparam int CTX_W       = $clog2(NUM_CTX),
  localparam int USERS       = NUM_CTX - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_evt,
  input  logic             trap_evt,
  input  logic             trap_ret,
  input  logic [USERS-1:0] loaded_mask,
  output logic             flush,
  output logic [CTX_W-1:0] ctx_ptr,
  output logic             sw_start,
  output cx_event_e        sw_kind,
  output logic [CTX_W-1:0] sw_from,
  output logic             sw_done,
  output logic [CTX_W-1:0] sw_to
);

  localparam int CNT_W = $clog2(FLUSH_CYCLES) + 1;
  localparam logic [CTX_W-1:0] TRAP_ID = CTX_W'(NUM_CTX - 1);
  localparam logic [CTX_W-1:0] LAST_RESET = CTX_W'(USERS - 1);

  // Round-robin search over user contexts, beginning after the last one run.
  function automatic logic [CTX_W:0] rr_pick(input logic [USERS-1:0] mask,
                                             input logic [CTX_W-1:0] last);
    logic [CTX_W:0] res;
    res = '0;
    for (int k = 1; k <= USERS; k++) begin
      int c;
      c = (int'(last) + k) % USERS;
      if (!res[CTX_W] && mask[c]) res = {1'b1, CTX_W'(c)};
    end
    return res;
  endfunction

  logic             flush_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CTX_W-1:0] ptr_q;
  logic [CTX_W-1:0] tgt_q;
  logic [CTX_W-1:0] last_q;

  logic [CTX_W:0]   pick;
  logic             pick_found;
  logic [CTX_W-1:0] pick_idx;
  logic             in_trap;
  cx_event_e        ev;
  logic [CTX_W-1:0] tgt_d;

  assign pick       = rr_pick(loaded_mask, last_q);
  assign pick_found = pick[CTX_W];
  assign pick_idx   = pick[CTX_W-1:0];
  assign in_trap    = (ptr_q == TRAP_ID);

  always_comb begin
    ev    = EV_NONE;
    tgt_d = TRAP_ID;
    if (!flush_q) begin
      if (!in_trap && trap_evt) begin
        ev    = EV_TRAP;
        tgt_d = TRAP_ID;
      end else if (!in_trap && miss_evt) begin
        ev    = EV_MISS;
        tgt_d = pick_found ? pick_idx : TRAP_ID;
      end else if (in_trap && trap_ret && pick_found) begin
        ev    = EV_RETURN;
        tgt_d = pick_idx;
      end
    end
  end

  assign sw_start = (ev != EV_NONE);
  assign sw_done  = flush_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= TRAP_ID;
      tgt_q   <= TRAP_ID;
      last_q  <= LAST_RESET;
    end else if (sw_start) begin
      flush_q <= 1'b1;
      cnt_q   <= CNT_W'(FLUSH_CYCLES - 1);
      tgt_q   <= tgt_d;
    end else if (sw_done) begin
      flush_q <= 1'b0;
      ptr_q   <= tgt_q;
      if (tgt_q != TRAP_ID) last_q <= tgt_q;
    end else if (flush_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign flush   = flush_q;
  assign ctx_ptr = ptr_q;
  assign sw_kind = ev;
  assign sw_from = ptr_q;
  assign sw_to   = tgt_q;

endmodule

// File: rtl/cxs_state_table.sv
module cxs_state_table
  import cxs_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int USERS  = NUM_CTX - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               sw_start,
  input  cx_event_e          sw_kind,
  input  logic [CTX_W-1:0]   sw_from,
  input  logic               sw_done,
  input  logic [CTX_W-1:0]   sw_to,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [CTX_W-1:0]   cmd_ctx,
  output logic [USERS-1:0]   loaded_mask,
  output logic               cmd_load_ok,
  output logic [2*NUM_CTX-1:0] state_flat
);

  logic             busy;
  logic [USERS-1:0] load_ok_vec;

  assign busy = flush | sw_start;

  genvar g;
  generate
    for (g = 0; g < NUM_CTX; g++) begin : g_ctx
      cx_state_e st_q;
      logic      leave_hit;
      logic      enter_hit;

      assign leave_hit = sw_start && (sw_from == CTX_W'(g));
      assign enter_hit = sw_done && (sw_to == CTX_W'(g));

      if (g == NUM_CTX - 1) begin : g_trap
        always_ff @(posedge clk) begin
          if (!rst_n)         st_q <= CX_ACTIVE;
          else if (leave_hit) st_q <= CX_LOADED;
          else if (enter_hit) st_q <= CX_ACTIVE;
        end
      end else begin : g_user
        logic cmd_hit;
        assign cmd_hit = cmd_valid && !busy && (cmd_ctx == CTX_W'(g));
        assign load_ok_vec[g] = cmd_hit && (cx_op_e'(cmd_op) == OP_LOAD) &&
                                (st_q == CX_UNLOADED);
        assign loaded_mask[g] = (st_q == CX_LOADED);

        always_ff @(posedge clk) begin
          if (!rst_n)         st_q <= CX_UNLOADED;
          else if (leave_hit) st_q <= leave_state(sw_kind);
          else if (enter_hit) st_q <= CX_ACTIVE;
          else if (cmd_hit)   st_q <= cmd_next_state(st_q, cx_op_e'(cmd_op));
        end
      end

      assign state_flat[2*g +: 2] = st_q;
    end
  endgenerate

  assign cmd_load_ok = |load_ok_vec;

endmodule

// File: rtl/cxs_pc_store.sv
module cxs_pc_store #(
  parameter int NUM_CTX            = 4,
  parameter int PC_W               = 32,
  parameter logic [PC_W-1:0] TRAP_PC  = PC_W'(32'h0000_0800),
  parameter logic [PC_W-1:0] TRAP_NPC = PC_W'(32'h0000_0804),
  localparam int CTX_W             = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic [CTX_W-1:0] sw_from,
  input  logic [PC_W-1:0]  evt_pc,
  input  logic [PC_W-1:0]  evt_npc,
  input  logic             cmd_load_ok,
  input  logic [CTX_W-1:0] cmd_ctx,
  input  logic [PC_W-1:0]  cmd_pc,
  input  logic [PC_W-1:0]  cmd_npc,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_npc
);

  logic [NUM_CTX*PC_W-1:0] pc_flat;
  logic [NUM_CTX*PC_W-1:0] npc_flat;

  genvar g;
  generate
    for (g = 0; g < NUM_CTX; g++) begin : g_slot
      if (g == NUM_CTX - 1) begin : g_fixed
        assign pc_flat[g*PC_W +: PC_W]  = TRAP_PC;
        assign npc_flat[g*PC_W +: PC_W] = TRAP_NPC;
      end else begin : g_saved
        logic [PC_W-1:0] pc_q;
        logic [PC_W-1:0] npc_q;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
          end else if (sw_start && sw_from == CTX_W'(g)) begin
            pc_q  <= evt_pc;
            npc_q <= evt_npc;
          end else if (cmd_load_ok && cmd_ctx == CTX_W'(g)) begin
            pc_q  <= cmd_pc;
            npc_q <= cmd_npc;
          end
        end
        assign pc_flat[g*PC_W +: PC_W]  = pc_q;
        assign npc_flat[g*PC_W +: PC_W] = npc_q;
      end
    end
  endgenerate

  assign rd_pc  = pc_flat[rd_ctx*PC_W +: PC_W];
  assign rd_npc = npc_flat[rd_ctx*PC_W +: PC_W];

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
  import cxs_pkg::*;
#(
  parameter int NUM_CTX            = 4,
  parameter int PC_W               = 32,
  parameter int FLUSH_CYCLES       = 4,
  parameter logic [PC_W-1:0] TRAP_PC  = PC_W'(32'h0000_0800),
  parameter logic [PC_W-1:0] TRAP_NPC = PC_W'(32'h0000_0804),
  localparam int CTX_W             = $clog2(NUM_CTX),
  localparam int USERS             = NUM_CTX - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_evt,
  input  logic                 trap_evt,
  input  logic                 trap_ret,
  input  logic [PC_W-1:0]      evt_pc,
  input  logic [PC_W-1:0]      evt_npc,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [CTX_W-1:0]     cmd_ctx,
  input  logic [PC_W-1:0]      cmd_pc,
  input  logic [PC_W-1:0]      cmd_npc,
  output logic                 flush,
  output logic [CTX_W-1:0]     ctx_ptr,
  output logic                 restart_valid,
  output logic [PC_W-1:0]      restart_pc,
  output logic [PC_W-1:0]      restart_npc,
  output logic [2*NUM_CTX-1:0] ctx_state
);

  logic             sw_start;
  cx_event_e        sw_kind;
  logic [CTX_W-1:0] sw_from;
  logic             sw_done;
  logic [CTX_W-1:0] sw_to;
  logic [USERS-1:0] loaded_mask;
  logic             cmd_load_ok;
  logic             restart_q;

  cxs_sequencer #(
    .NUM_CTX      (NUM_CTX),
    .FLUSH_CYCLES (FLUSH_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_evt    (miss_evt),
    .trap_evt    (trap_evt),
    .trap_ret    (trap_ret),
    .loaded_mask (loaded_mask),
    .flush       (flush),
    .ctx_ptr     (ctx_ptr),
    .sw_start    (sw_start),
    .sw_kind     (sw_kind),
    .sw_from     (sw_from),
    .sw_done     (sw_done),
    .sw_to       (sw_to)
  );

  cxs_state_table #(
    .NUM_CTX (NUM_CTX)
  ) u_states (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .sw_start    (sw_start),
    .sw_kind     (sw_kind),
    .sw_from     (sw_from),
    .sw_done     (sw_done),
    .sw_to       (sw_to),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_ctx     (cmd_ctx),
    .loaded_mask (loaded_mask),
    .cmd_load_ok (cmd_load_ok),
    .state_flat  (ctx_state)
  );

  cxs_pc_store #(
    .NUM_CTX  (NUM_CTX),
    .PC_W     (PC_W),
    .TRAP_PC  (TRAP_PC),
    .TRAP_NPC (TRAP_NPC)
  ) u_pcs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_start    (sw_start),
    .sw_from     (sw_from),
    .evt_pc      (evt_pc),
    .evt_npc     (evt_npc),
    .cmd_load_ok (cmd_load_ok),
    .cmd_ctx     (cmd_ctx),
    .cmd_pc      (cmd_pc),
    .cmd_npc     (cmd_npc),
    .rd_ctx      (ctx_ptr),
    .rd_pc       (restart_pc),
    .rd_npc      (restart_npc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= sw_done;
  end

  assign restart_valid = restart_q;

endmodule

// File: rtl/cxs_checker.sv
module cxs_checker #(
  parameter int NUM_CTX      = 4,
  parameter int FLUSH_CYCLES = 4,
  localparam int CTX_W       = $clog2(NUM_CTX),
  localparam int CW          = $clog2(FLUSH_CYCLES + 1) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trap_evt,
  input logic                 flush,
  input logic [CTX_W-1:0]     ctx_ptr,
  input logic                 restart_valid,
  input logic [2*NUM_CTX-1:0] ctx_state
);

  localparam logic [CTX_W-1:0] TRAP_ID = CTX_W'(NUM_CTX - 1);

  logic [CW-1:0] fl_cnt;
  int            act_cnt;
  logic          ptr_active;

  always_ff @(posedge clk) begin
    if (!rst_n)     fl_cnt <= '0;
    else if (flush) fl_cnt <= fl_cnt + CW'(1);
    else            fl_cnt <= '0;
  end

  always_comb begin
    act_cnt = 0;
    for (int i = 0; i < NUM_CTX; i++)
      if (ctx_state[2*i +: 2] == 2'd2) act_cnt = act_cnt + 1;
  end

  assign ptr_active = (ctx_state[ctx_ptr*2 +: 2] == 2'd2);

  // R4
  flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> fl_cnt < CW'(FLUSH_CYCLES));

  // R4
  flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> fl_cnt == CW'(FLUSH_CYCLES));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctx_ptr) |-> $fell(flush));

  // R4
  no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> act_cnt == 0);

  // R6
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (act_cnt == 1 && ptr_active));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> $fell(flush));

  // R7
  trap_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_evt && !flush && ctx_ptr != TRAP_ID) |=> flush);

endmodule

bind ctx_switch_ctrl cxs_checker #(
  .NUM_CTX      (NUM_CTX),
  .FLUSH_CYCLES (FLUSH_CYCLES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trap_evt      (trap_evt),
  .flush         (flush),
  .ctx_ptr       (ctx_ptr),
  .restart_valid (restart_valid),
  .ctx_state     (ctx_state)
);

// File: tb/test_ctx_switch_ctrl.sv
`timescale 1ns/1ps
module test_ctx_switch_ctrl;

  localparam int FL = 4;
  localparam logic [31:0] TPC  = 32'h0000_0800;
  localparam logic [31:0] TNPC = 32'h0000_0804;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_evt = 1'b0, trap_evt = 1'b0, trap_ret = 1'b0;
  logic [31:0] evt_pc = '0, evt_npc = '0, cmd_pc = '0, cmd_npc = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0, cmd_ctx = '0;
  logic        flush, restart_valid;
  logic [1:0]  ctx_ptr;
  logic [31:0] restart_pc, restart_npc;
  logic [7:0]  ctx_state;

  always #4 clk = ~clk;

  ctx_switch_ctrl i_ctx_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_evt(miss_evt), .trap_evt(trap_evt),
    .trap_ret(trap_ret), .evt_pc(evt_pc), .evt_npc(evt_npc),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ctx(cmd_ctx),
    .cmd_pc(cmd_pc), .cmd_npc(cmd_npc), .flush(flush), .ctx_ptr(ctx_ptr),
    .restart_valid(restart_valid), .restart_pc(restart_pc),
    .restart_npc(restart_npc), .ctx_state(ctx_state)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model: 0 unloaded, 1 loaded, 2 active, 3 suspended
  int          mst[4];
  logic [31:0] mpc[4], mnpc[4];
  int          mptr, mtgt, mlast, mcnt;
  bit          mflush, mrv;
  string       mtag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin mst[i] = 0; mpc[i] = '0; mnpc[i] = '0; end
    mst[3] = 2; mpc[3] = TPC; mnpc[3] = TNPC;
    mptr = 3; mtgt = 3; mlast = 2; mcnt = 0; mflush = 0; mrv = 0; mtag = "R1";
  endtask

  function automatic int rr_next();
    for (int k = 1; k <= 3; k++) begin
      int c = (mlast + k) % 3;
      if (mst[c] == 1) return c;
    end
    return -1;
  endfunction

  function automatic int cmd_result(int cur, int op);
    if (op == 0 && cur == 0) return 1;
    if (op == 1 && (cur == 1 || cur == 3)) return 0;
    if (op == 2 && cur == 1) return 3;
    if (op == 3 && cur == 3) return 1;
    return cur;
  endfunction

  task automatic model_step();
    int pk;
    mrv = 0;
    if (mflush) begin
      mtag = "R9";
      if (mcnt == 0) begin
        mflush = 0; mptr = mtgt; mst[mtgt] = 2; mrv = 1;
        if (mtgt != 3) mlast = mtgt;
      end else mcnt--;
      return;
    end
    pk = rr_next();
    if (mptr != 3 && trap_evt) begin
      mst[mptr] = 1; mpc[mptr] = evt_pc; mnpc[mptr] = evt_npc;
      mtgt = 3; mflush = 1; mcnt = FL - 1; mtag = "R7";
    end else if (mptr != 3 && miss_evt) begin
      mst[mptr] = 3; mpc[mptr] = evt_pc; mnpc[mptr] = evt_npc;
      mtgt = (pk >= 0) ? pk : 3; mflush = 1; mcnt = FL - 1; mtag = "R3";
    end else if (mptr == 3 && trap_ret && pk >= 0) begin
      mst[3] = 1; mtgt = pk; mflush = 1; mcnt = FL - 1; mtag = "R8";
    end else begin
      mtag = (mptr == 3) ? "R8" : "R2";
      if (cmd_valid && cmd_ctx != 2'd3) begin
        int c = int'(cmd_ctx);
        if (int'(cmd_op) == 0 && mst[c] == 0) begin
          mpc[c] = cmd_pc; mnpc[c] = cmd_npc;
        end
        mst[c] = cmd_result(mst[c], int'(cmd_op));
      end
    end
  endtask

  task automatic compare(input string first);
    string t;
    int nact = 0;
    t = (first != "") ? first : mtag;
    chk(flush == mflush, (first != "") ? first : "R4", "flush", flush, mflush);
    chk(int'(ctx_ptr) == mptr, t, "ctx_ptr", ctx_ptr, mptr);
    for (int i = 0; i < 4; i++) begin
      chk(int'(ctx_state[2*i +: 2]) == mst[i], t, $sformatf("state[%0d]", i),
          ctx_state[2*i +: 2], mst[i]);
      if (ctx_state[2*i +: 2] == 2'd2) nact++;
    end
    // R6: one active context outside a flush
    if (!flush) chk(nact == 1, "R6", "active count", nact, 1);
    // R5: restart strobe and restart point
    chk(restart_valid == mrv, "R5", "restart_valid", restart_valid, mrv);
    if (mrv) begin
      chk(restart_pc == mpc[mptr], "R5", "restart_pc", restart_pc, mpc[mptr]);
      chk(restart_npc == mnpc[mptr], "R5", "restart_npc", restart_npc, mnpc[mptr]);
    end
  endtask

  task automatic drive(input bit mi, input bit tr, input bit rt, input bit cv,
                       input int op, input int cx, input logic [31:0] p);
    miss_evt = mi; trap_evt = tr; trap_ret = rt; cmd_valid = cv;
    cmd_op = 2'(op); cmd_ctx = 2'(cx);
    evt_pc = p; evt_npc = p + 32'd4; cmd_pc = p ^ 32'h00F0_0000;
    cmd_npc = cmd_pc + 32'd4;
    model_step();
  endtask

  // one cycle: check current outputs, then present new inputs
  task automatic cyc(input bit mi, input bit tr, input bit rt, input bit cv,
                     input int op, input int cx, input logic [31:0] p);
    @(negedge clk);
    compare("");
    drive(mi, tr, rt, cv, op, cx, p);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");  // R1 reset state
    drive(0, 0, 0, 0, 0, 0, 32'h0);
    // R8: return with no loaded user context is ignored; miss in handler ignored
    cyc(0, 0, 1, 0, 0, 0, 32'h0);
    cyc(1, 0, 0, 0, 0, 0, 32'h0);
    // R2: command on handler context is ignored; loads of user contexts
    cyc(0, 0, 0, 1, 0, 3, 32'h40);
    cyc(0, 0, 0, 1, 0, 0, 32'h100);
    cyc(0, 0, 0, 1, 0, 1, 32'h200);
    cyc(0, 0, 0, 1, 0, 2, 32'h300);
    cyc(0, 0, 0, 1, 2, 2, 32'h0);       // suspend ctx 2
    // R8: return goes to context 0 (round-robin after 2)
    cyc(0, 0, 1, 0, 0, 0, 32'h0);
    // R9: events and commands during the flush are dropped
    cyc(1, 1, 1, 1, 1, 1, 32'h77);
    idle(5);
    // R7 over R3: trap and miss together
    cyc(1, 1, 0, 0, 0, 0, 32'h108);
    idle(6);
    cyc(0, 0, 1, 0, 0, 0, 32'h0);       // return: ctx 1 is next
    idle(6);
    // R3: miss with only suspended / active threads falls to handler
    cyc(0, 0, 0, 1, 1, 0, 32'h0);       // unload ctx 0
    cyc(1, 0, 0, 0, 0, 0, 32'h208);
    idle(6);
    cyc(0, 0, 0, 1, 3, 1, 32'h0);       // wake ctx 1
    cyc(0, 0, 0, 1, 3, 2, 32'h0);       // wake ctx 2
    cyc(0, 0, 1, 0, 0, 0, 32'h0);
    idle(6);
    // random phase
    void'($urandom(32'h5EED_C0DE));
    for (int n = 0; n < 6000; n++) begin
      int r = int'($urandom_range(99, 0));
      cyc(r < 8, (r % 17) == 3, $urandom_range(99, 0) < 20,
          $urandom_range(99, 0) < 45, int'($urandom_range(3, 0)),
          int'($urandom_range(3, 0)), $urandom & 32'hFFFF_FFFC);
    end
    @(negedge clk);
    compare("");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule